// File: doc/BRIEF.md
# Delay-Slot Fetch Address Unit

This unit owns the fetch program counter of a pipeline whose instruction set defines exactly one branch delay slot. Every cycle it presents the address to fetch. It also keeps the address of the instruction now in decode. When a branch is resolved it accepts one event with a kind, a taken flag, an offset and a register value. The instruction fetched in that same cycle is the delay slot. It is always fetched. Fetch then continues either at the branch target or sequentially.

A branch can be marked annulling. When an annulling conditional branch falls through, its slot instruction is cancelled. A squash flag travels with that instruction through decode, and a small gate clears its register-write and memory-write enables on the way to execute. Fetch timing is never altered by a squash. A branch that sits in another branch's delay slot is an illegal sequence. Its redirect is dropped and a fault pulse is raised.

Instruction memory, decode and condition evaluation live elsewhere. Conditions arrive already resolved.

Top module: `dslot_fetch_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, fetch_pc equals RESET_PC (default 0x100). In that same state, dec_valid, dec_squash, seq_fault, ex_rf_we and ex_mem_we are all 0.
- R2: With no accepted redirect, fetch_pc advances by 4 each cycle, modulo 2^XLEN. dec_pc takes the previous cycle's fetch_pc, and dec_valid is 1 from the second cycle after reset.
- R3: br_valid is asserted in the cycle where decode holds the branch, whose address is dec_pc. The instruction at fetch_pc in that cycle is the delay slot and is always fetched. At the next edge fetch_pc becomes the target if the branch is taken, otherwise the slot address plus 4.
- R4: br_kind 2'b00 is a conditional branch, taken per br_taken. br_kind 2'b01 is a jump or call and is always taken. For both kinds the target is dec_pc plus the sign-extended br_offset, with bits [1:0] cleared.
- R5: br_kind 2'b10 is an indirect jump and 2'b11 is a return. Both are always taken, and the target is br_reg with bits [1:0] cleared, so fetch_pc[1:0] is always 0.
- R6: One cycle after an accepted conditional branch with br_annul=1 and br_taken=0, dec_squash is 1 while the slot instruction sits in decode. In every other case dec_squash is 0, including an annulling branch that is taken and br_annul on the always-taken kinds.
- R7: One cycle after decode, ex_rf_we and ex_mem_we equal dec_rf_we_in and dec_mem_we_in of that instruction, ANDed with NOT dec_squash.
- R8: A br_valid whose branch is itself a delay-slot instruction is ignored. Fetch stays sequential and no squash is produced. seq_fault pulses 1 for one cycle, and the instruction after that ignored branch is not treated as a slot.
- R9: br_valid while dec_valid is 0 is ignored, and fetch stays sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch in decode is resolved this cycle |
| br_kind | input | 2 | 00 conditional, 01 jump/call, 10 indirect, 11 return |
| br_taken | input | 1 | Resolved direction of a conditional branch |
| br_annul | input | 1 | Branch cancels its slot when it falls through |
| br_offset | input | OFF_W | Signed byte offset for PC-relative kinds |
| br_reg | input | XLEN | Register target for indirect and return kinds |
| dec_rf_we_in | input | 1 | Register-write enable of the instruction in decode |
| dec_mem_we_in | input | 1 | Memory-write enable of the instruction in decode |
| fetch_pc | output | XLEN | Address fetched this cycle |
| dec_pc | output | XLEN | Address of the instruction in decode |
| dec_valid | output | 1 | Decode holds a real instruction |
| dec_squash | output | 1 | Instruction in decode is an annulled slot |
| seq_fault | output | 1 | Branch-in-slot sequence was seen and ignored |
| ex_rf_we | output | 1 | Gated register-write enable entering execute |
| ex_mem_we | output | 1 | Gated memory-write enable entering execute |

## Verification
The bench sweeps every kind, direction and annul setting across offsets that include the most negative value and address wrap. It also uses register targets whose low bits are set. Several faults are aimed at directly. A design that applied the annul rule to taken branches, or to the always-taken kinds, would squash a slot that should commit and lose its writes. A design that redirected right after the branch instead of after its slot would skip the slot. A design that honoured a branch in a slot would jump twice, and one that kept the slot state set afterwards would ignore the next legal branch. Reset and the first cycle out of reset are checked so that a stray br_valid cannot move fetch before decode holds anything.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  typedef enum logic [1:0] {
    BK_COND     = 2'b00,
    BK_DIRECT   = 2'b01,
    BK_INDIRECT = 2'b10,
    BK_RETURN   = 2'b11
  } br_kind_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned ALIGN_BITS = 2;

  function automatic logic uses_pc_rel(input br_kind_e k);
    return (k == BK_COND) || (k == BK_DIRECT);
  endfunction

endpackage

// File: rtl/dslot_target_calc.sv
module dslot_target_calc
  import dslot_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFF_W = 16
) (
  input  logic [1:0]      kind,
  input  logic            taken_in,
  input  logic [OFF_W-1:0] offset,
  input  logic [XLEN-1:0] reg_val,
  input  logic [XLEN-1:0] base_pc,
  output logic            take,
  output logic            is_cond,
  output logic [XLEN-1:0] target
);
  localparam int unsigned EXT_W = XLEN - OFF_W;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'((1 << ALIGN_BITS) - 1);

  br_kind_e        k;
  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] raw;

  assign k       = br_kind_e'(kind);
  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign is_cond = (k == BK_COND);

  always_comb begin
    if (uses_pc_rel(k)) raw = base_pc + off_ext;
    else                raw = reg_val;
  end

  always_comb begin
    unique case (k)
      BK_COND: take = taken_in;
      default: take = 1'b1;
    endcase
  end

  assign target = raw & ALIGN_MASK;
endmodule

// File: rtl/dslot_slot_ctrl.sv
module dslot_slot_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic br_valid,
  input  logic dec_valid,
  input  logic is_cond,
  input  logic take,
  input  logic annul,
  output logic redirect,
  output logic squash_q,
  output logic fault_q
);
  logic in_slot_q;
  logic accept;
  logic illegal;

  assign accept   = br_valid & dec_valid & ~in_slot_q;
  assign illegal  = br_valid & dec_valid & in_slot_q;
  assign redirect = accept & take;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_slot_q <= 1'b0;
      squash_q  <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      in_slot_q <= accept;
      squash_q  <= accept & is_cond & annul & ~take;
      fault_q   <= illegal;
    end
  end
endmodule

// File: rtl/dslot_commit_gate.sv
module dslot_commit_gate #(
  parameter int unsigned N_EN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            squash,
  input  logic [N_EN-1:0] en_in,
  output logic [N_EN-1:0] en_out
);
  for (genvar g = 0; g < N_EN; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst) en_out[g] <= 1'b0;
      else     en_out[g] <= en_in[g] & ~squash;
    end
  end
endmodule

// File: rtl/dslot_fetch_unit.sv
module dslot_fetch_unit
  import dslot_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     OFF_W    = 16,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [1:0]       br_kind,
  input  logic             br_taken,
  input  logic             br_annul,
  input  logic [OFF_W-1:0] br_offset,
  input  logic [XLEN-1:0]  br_reg,
  input  logic             dec_rf_we_in,
  input  logic             dec_mem_we_in,
  output logic [XLEN-1:0]  fetch_pc,
  output logic [XLEN-1:0]  dec_pc,
  output logic             dec_valid,
  output logic             dec_squash,
  output logic             seq_fault,
  output logic             ex_rf_we,
  output logic             ex_mem_we
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  localparam int unsigned     N_EN = 2;

  logic            take;
  logic            is_cond;
  logic [XLEN-1:0] target;
  logic            redirect;
  logic [N_EN-1:0] en_in;
  logic [N_EN-1:0] en_out;

  dslot_target_calc #(.XLEN(XLEN), .OFF_W(OFF_W)) calc_i (
    .kind     (br_kind),
    .taken_in (br_taken),
    .offset   (br_offset),
    .reg_val  (br_reg),
    .base_pc  (dec_pc),
    .take     (take),
    .is_cond  (is_cond),
    .target   (target)
  );

  dslot_slot_ctrl slot_i (
    .clk       (clk),
    .rst       (rst),
    .br_valid  (br_valid),
    .dec_valid (dec_valid),
    .is_cond   (is_cond),
    .take      (take),
    .annul     (br_annul),
    .redirect  (redirect),
    .squash_q  (dec_squash),
    .fault_q   (seq_fault)
  );

  assign en_in = {dec_mem_we_in, dec_rf_we_in};

  dslot_commit_gate #(.N_EN(N_EN)) gate_i (
    .clk    (clk),
    .rst    (rst),
    .squash (dec_squash),
    .en_in  (en_in),
    .en_out (en_out)
  );

  assign ex_rf_we  = en_out[0];
  assign ex_mem_we = en_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc  <= RESET_PC;
      dec_pc    <= '0;
      dec_valid <= 1'b0;
    end else begin
      fetch_pc  <= redirect ? target : fetch_pc + STEP;
      dec_pc    <= fetch_pc;
      dec_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/dslot_fetch_unit_chk.sv
module dslot_fetch_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            br_valid,
  input logic [1:0]      br_kind,
  input logic            br_taken,
  input logic            br_annul,
  input logic [XLEN-1:0] fetch_pc,
  input logic [XLEN-1:0] dec_pc,
  input logic            dec_valid,
  input logic            dec_squash,
  input logic            seq_fault,
  input logic            ex_rf_we,
  input logic            ex_mem_we
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= ~rst;

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!br_valid) |-> fetch_pc == $past(fetch_pc) + XLEN'(4));

  assert_dec_follows_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> dec_pc == $past(fetch_pc));

  assert_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_pc[1:0] == 2'b00);

  assert_squash_cause_R6: assert property (@(posedge clk) disable iff (rst)
    dec_squash |-> $past(br_valid && br_annul && !br_taken && br_kind == 2'b00));

  assert_gate_clears_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(dec_squash) |-> !ex_rf_we && !ex_mem_we);

  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (rst)
    seq_fault |-> $past(br_valid) && !dec_squash);

  assert_idle_decode_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(br_valid && !dec_valid) |-> fetch_pc == $past(fetch_pc) + XLEN'(4));

  assert_valid_after_R2: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> dec_valid);
endmodule

bind dslot_fetch_unit dslot_fetch_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .br_valid   (br_valid),
  .br_kind    (br_kind),
  .br_taken   (br_taken),
  .br_annul   (br_annul),
  .fetch_pc   (fetch_pc),
  .dec_pc     (dec_pc),
  .dec_valid  (dec_valid),
  .dec_squash (dec_squash),
  .seq_fault  (seq_fault),
  .ex_rf_we   (ex_rf_we),
  .ex_mem_we  (ex_mem_we)
);

// File: tb/dslot_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module dslot_fetch_unit_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int unsigned OFF_W = 16;
  localparam logic [31:0] RPC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid, br_taken, br_annul, dec_rf_we_in, dec_mem_we_in;
  logic [1:0] br_kind;
  logic [15:0] br_offset;
  logic [31:0] br_reg;
  logic [31:0] fetch_pc, dec_pc;
  logic dec_valid, dec_squash, seq_fault, ex_rf_we, ex_mem_we;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dslot_fetch_unit #(.XLEN(XLEN), .OFF_W(OFF_W), .RESET_PC(RPC)) dut_i (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_kind(br_kind),
    .br_taken(br_taken), .br_annul(br_annul), .br_offset(br_offset),
    .br_reg(br_reg), .dec_rf_we_in(dec_rf_we_in), .dec_mem_we_in(dec_mem_we_in),
    .fetch_pc(fetch_pc), .dec_pc(dec_pc), .dec_valid(dec_valid),
    .dec_squash(dec_squash), .seq_fault(seq_fault),
    .ex_rf_we(ex_rf_we), .ex_mem_we(ex_mem_we)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    br_valid = 1'b0; br_kind = 2'b00; br_taken = 1'b0; br_annul = 1'b0;
    br_offset = '0; br_reg = '0; dec_rf_we_in = 1'b0; dec_mem_we_in = 1'b0;
  endtask

  task automatic drive_br(input logic [1:0] k, input logic t, input logic a,
                          input logic [15:0] off, input logic [31:0] rv);
    br_valid = 1'b1; br_kind = k; br_taken = t; br_annul = a;
    br_offset = off; br_reg = rv;
  endtask

  function automatic logic [31:0] exp_tgt(input logic [1:0] k, input logic [31:0] d,
                                          input logic [15:0] off, input logic [31:0] rv);
    logic [31:0] r;
    if (k[1] == 1'b0) r = d + {{16{off[15]}}, off};
    else              r = rv;
    return r & 32'hFFFF_FFFC;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] f, d, t1, tg;
    logic [15:0] offs [4];
    logic [31:0] regs [4];
    offs[0] = 16'h0008; offs[1] = 16'hFFF0; offs[2] = 16'h7FFC; offs[3] = 16'h8000;
    regs[0] = 32'h8000_1003; regs[1] = 32'h0000_0FFE;
    regs[2] = 32'h1234_5678; regs[3] = 32'hFFFF_FFFD;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "fetch_pc in reset", fetch_pc, RPC);
    check("R1", "dec_valid in reset", {31'b0, dec_valid}, 0);
    check("R1", "squash/fault/ex in reset",
          {28'b0, dec_squash, seq_fault, ex_rf_we, ex_mem_we}, 0);
    rst = 1'b0;
    // R9: branch event while decode is empty
    drive_br(2'b01, 1'b1, 1'b0, 16'h0040, 32'h0);
    dec_rf_we_in = 1'b1; dec_mem_we_in = 1'b1;
    @(negedge clk);
    check("R9", "fetch ignores br while decode empty", fetch_pc, RPC + 4);
    check("R2", "dec_valid after first cycle", {31'b0, dec_valid}, 1);
    check("R2", "dec_pc follows fetch", dec_pc, RPC);
    idle();
    for (int i = 0; i < 3; i++) begin
      f = fetch_pc;
      @(negedge clk);
      check("R2", "sequential step", fetch_pc, f + 4);
      check("R2", "dec_pc previous fetch", dec_pc, f);
    end

    // Sweep: kind x direction x annul x operand
    for (int k = 0; k < 4; k++)
      for (int t = 0; t < 2; t++)
        for (int a = 0; a < 2; a++)
          for (int o = 0; o < 4; o++) begin
            logic take, sq;
            f = fetch_pc; d = dec_pc;
            drive_br(2'(k), 1'(t), 1'(a), offs[o], regs[o]);
            dec_rf_we_in = 1'b1; dec_mem_we_in = 1'b1;
            take = (k == 0) ? 1'(t) : 1'b1;
            sq = (k == 0) && (a == 1) && (t == 0);
            tg = take ? exp_tgt(2'(k), d, offs[o], regs[o]) : f + 4;
            @(negedge clk);
            check(k < 2 ? "R4" : "R5", "next fetch after slot", fetch_pc, tg);
            check("R3", "slot enters decode", dec_pc, f);
            check("R6", "squash flag", {31'b0, dec_squash}, {31'b0, sq});
            check("R7", "branch enables pass", {30'b0, ex_mem_we, ex_rf_we}, 3);
            check("R8", "no fault on legal branch", {31'b0, seq_fault}, 0);
            idle();
            dec_rf_we_in = 1'b1; dec_mem_we_in = (o[0] == 1'b0);
            @(negedge clk);
            check("R7", "slot rf enable gated", {31'b0, ex_rf_we}, {31'b0, !sq});
            check("R7", "slot mem enable gated", {31'b0, ex_mem_we},
                  {31'b0, !sq && (o[0] == 0)});
            check("R3", "fetch continues from target", fetch_pc, tg + 4);
            idle();
            @(negedge clk);
          end

    // R8: branch in a delay slot, taken form
    d = dec_pc; f = fetch_pc;
    drive_br(2'b00, 1'b1, 1'b0, 16'h0020, 32'h0);
    t1 = exp_tgt(2'b00, d, 16'h0020, 32'h0);
    @(negedge clk);
    check("R3", "first branch redirect", fetch_pc, t1);
    drive_br(2'b01, 1'b1, 1'b0, 16'h0400, 32'h0);
    @(negedge clk);
    check("R8", "slot branch redirect ignored", fetch_pc, t1 + 4);
    check("R8", "fault pulse", {31'b0, seq_fault}, 1);
    check("R8", "no squash on slot branch", {31'b0, dec_squash}, 0);
    d = dec_pc;
    drive_br(2'b01, 1'b1, 1'b0, 16'h0040, 32'h0);
    @(negedge clk);
    check("R8", "following branch honoured", fetch_pc, exp_tgt(2'b01, d, 16'h0040, 32'h0));
    check("R8", "fault clears", {31'b0, seq_fault}, 0);
    idle();
    @(negedge clk);
    @(negedge clk);

    // R8: annulling not-taken branch inside a slot does not squash
    d = dec_pc;
    drive_br(2'b01, 1'b1, 1'b0, 16'h0010, 32'h0);
    t1 = exp_tgt(2'b01, d, 16'h0010, 32'h0);
    @(negedge clk);
    drive_br(2'b00, 1'b0, 1'b1, 16'h0100, 32'h0);
    @(negedge clk);
    check("R8", "annul in slot no squash", {31'b0, dec_squash}, 0);
    check("R8", "annul in slot fetch sequential", fetch_pc, t1 + 4);
    check("R8", "annul in slot fault", {31'b0, seq_fault}, 1);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule